// File: doc/BRIEF.md
# Compare-and-Branch Condition Evaluator

This block decides whether a conditional branch is taken and produces the address to continue from. The issuing stage provides the address of the branch, the fall-through address, the two register operands, a four-bit condition code, a constant-table index, a four-bit bit-position field and a twelve-bit offset field. It also provides a two-bit branch class. The class chooses what the first operand is compared against and how wide the offset is. The decision and the target are registered once. Both appear one clock after the request strobe.

The comparand comes from one of three places: the second register operand, zero, or a constant from one of two small tables. The tables hold irregular values. The signed table starts at minus one. The unsigned table starts at 32768 and 65536. The high bit of the condition code flips the sense of every test. The remaining three bits select the test: mask none/all, equality, signed or unsigned ordering, or a single-bit test with the bit position taken from a register or from the instruction.

Top module: `brc_unit`

Class encoding on `class_i`: 0 = operand/operand, 1 = operand/constant table, 2 = operand/zero with wide offset, 3 = short zero test. The test code is `cond_i[2:0]`. The inversion is `cond_i[3]`.

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs go to zero after that edge: `res_valid_o`, `taken_o` and `target_o`.
- R2: A request with `valid_i` high at edge k gives `res_valid_o` high after edge k, and the result applies to that request. If `valid_i` is low at edge k, `res_valid_o` and `taken_o` are low after it and `target_o` keeps its value.
- R3: In class 0, codes 1, 2 and 3 are taken when `opa_i` equals `opb_i`, is signed-less than it, or is unsigned-less than it. Codes 9, 10 and 11 are taken when those tests fail.
- R4: In class 0, code 0 is taken when (`opa_i` AND `opb_i`) is zero, and code 8 when it is not zero. Code 4 is taken when (`opa_i` AND `opb_i`) equals `opb_i`, and code 12 when it does not.
- R5: In class 0, code 5 is taken when bit `opb_i[4:0]` of `opa_i` is 0. Code 13 is taken when that bit is 1.
- R6: In class 0, codes 6 and 7 are taken when bit {`cond_i[0]`, `bidx_i`} of `opa_i` is 0. Codes 14 and 15 are taken when that bit is 1.
- R7: In class 1, codes 1/9 and 2/10 compare `opa_i` with the signed table entry. That table maps index 0 to -1, indices 1 to 8 to themselves, and indices 9 to 15 to 10, 12, 16, 32, 64, 128 and 256. Codes 3/11 compare against the unsigned table, which equals the signed table except that index 0 is 32768 and index 1 is 65536.
- R8: In class 2, codes 1, 2 and 3 (and 9, 10, 11 inverted) compare `opa_i` against zero with the R3 tests. A taken branch targets `pc_i` + 4 + `offset_i` sign-extended from 12 bits.
- R9: In class 3, the branch is taken when `opa_i` is zero and `cond_i[3]` is 0, or when `opa_i` is non-zero and `cond_i[3]` is 1. A taken branch targets `pc_i` + 4 + `offset_i[5:0]` zero-extended.
- R10: In classes 1 and 2, codes 0 and 4 to 8 and 12 to 15 are never taken.
- R11: A taken branch in class 0 or 1 targets `pc_i` + 4 + `offset_i[7:0]` sign-extended. Any request that is not taken reports `fall_pc_i` as its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| class_i | input | 2 | Branch class |
| cond_i | input | 4 | Inversion bit and test code |
| cidx_i | input | 4 | Constant table index |
| bidx_i | input | 4 | Low four bits of the immediate bit position |
| pc_i | input | 32 | Address of the branch |
| fall_pc_i | input | 32 | Fall-through address |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| offset_i | input | 12 | Offset field |
| res_valid_o | output | 1 | Result strobe |
| taken_o | output | 1 | Branch taken |
| target_o | output | 32 | Next address |

## Verification
On every cycle the assertions check the request-to-result timing and the idle behaviour. They also check that a failed test reports the fall-through address. Three more properties run on every cycle: equality compares, the short-class target arithmetic, and the rule that unused codes are never taken. The bench alone checks the table contents at each index and the signed and unsigned ordering at the boundaries. It also covers both bit-test forms up to bit 31 and the extreme wide and short offsets, using a reference model over a long random mix of classes and codes.

// File: rtl/brc_pkg.sv
// Package for the branch evaluator: class encoding, test codes and the two
// compare-constant tables. Assumes a datapath of at least 18 bits.
package brc_pkg;

    localparam int BRC_XLEN = 32;

    typedef enum logic [1:0] {
        CLS_REG   = 2'd0,
        CLS_CONST = 2'd1,
        CLS_ZERO  = 2'd2,
        CLS_SHORT = 2'd3
    } brc_cls_e;

    // Low three bits of the condition code
    localparam logic [2:0] TST_MNONE = 3'd0;
    localparam logic [2:0] TST_EQ    = 3'd1;
    localparam logic [2:0] TST_LT    = 3'd2;
    localparam logic [2:0] TST_LTU   = 3'd3;
    localparam logic [2:0] TST_MALL  = 3'd4;
    localparam logic [2:0] TST_BREG  = 3'd5;
    localparam logic [2:0] TST_BIMA  = 3'd6;
    localparam logic [2:0] TST_BIMB  = 3'd7;

    // Signed table entry as an 18-bit signed value
    function automatic logic signed [17:0] sconst(input logic [3:0] idx);
        logic signed [17:0] v;
        case (idx)
            4'd0:    v = -18'sd1;
            4'd9:    v = 18'sd10;
            4'd10:   v = 18'sd12;
            4'd11:   v = 18'sd16;
            4'd12:   v = 18'sd32;
            4'd13:   v = 18'sd64;
            4'd14:   v = 18'sd128;
            4'd15:   v = 18'sd256;
            default: v = 18'(idx);
        endcase
        return v;
    endfunction

    // Unsigned table entry: two large entries, otherwise the signed table
    function automatic logic signed [17:0] uconst(input logic [3:0] idx);
        logic signed [17:0] v;
        case (idx)
            4'd0:    v = 18'sd32768;
            4'd1:    v = 18'sd65536;
            default: v = sconst(idx);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/brc_operand_sel.sv
// Chooses the comparand for the first operand: the second register
// operand, an entry of the signed or unsigned constant table, or zero.
// Assumes XLEN >= 18 so table entries fit after sign extension.
module brc_operand_sel
    import brc_pkg::*;
#(
    parameter int XLEN    = BRC_XLEN,
    parameter int TBL_N   = 16,
    localparam int IDX_W  = $clog2(TBL_N)
) (
    input  logic [1:0]      class_i,
    input  logic [2:0]      test_i,
    input  logic [IDX_W-1:0] cidx_i,
    input  logic [XLEN-1:0] opb_i,
    output logic [XLEN-1:0] cmp_b_o
);

    localparam int VAL_W = 18;

    logic [XLEN-1:0] stab [TBL_N];
    logic [XLEN-1:0] utab [TBL_N];

    // Table entries computed per index and sign-extended to the datapath
    for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
        localparam logic signed [VAL_W-1:0] SV = sconst(4'(g));
        localparam logic signed [VAL_W-1:0] UV = uconst(4'(g));
        assign stab[g] = {{(XLEN-VAL_W){SV[VAL_W-1]}}, SV};
        assign utab[g] = {{(XLEN-VAL_W){UV[VAL_W-1]}}, UV};
    end

    // Comparand mux by class; the unsigned ordering test uses the unsigned table
    always_comb begin
        unique case (brc_cls_e'(class_i))
            CLS_REG:   cmp_b_o = opb_i;
            CLS_CONST: cmp_b_o = (test_i == TST_LTU) ? utab[cidx_i] : stab[cidx_i];
            default:   cmp_b_o = '0;
        endcase
    end

endmodule

// File: rtl/brc_cond_eval.sv
// Evaluates the branch condition for one request. Computes the primitive
// relations once, picks one by test code and class, then applies the
// inversion bit. Assumes XLEN is a power of two for the bit index.
module brc_cond_eval
    import brc_pkg::*;
#(
    parameter int XLEN   = BRC_XLEN,
    localparam int BIT_W = $clog2(XLEN)
) (
    input  logic [1:0]       class_i,
    input  logic [3:0]       cond_i,
    input  logic [BIT_W-2:0] bidx_i,
    input  logic [XLEN-1:0]  opa_i,
    input  logic [XLEN-1:0]  cmp_b_i,
    output logic             taken_o
);

    logic [XLEN-1:0]  anded;
    logic             rel_eq, rel_lt, rel_ltu, rel_none, rel_all;
    logic [BIT_W-1:0] pos_reg, pos_imm;
    logic             bit_clr_reg, bit_clr_imm;
    logic             base, legal;

    // Primitive relations between the operand and its comparand
    always_comb begin
        anded    = opa_i & cmp_b_i;
        rel_eq   = (opa_i == cmp_b_i);
        rel_lt   = ($signed(opa_i) < $signed(cmp_b_i));
        rel_ltu  = (opa_i < cmp_b_i);
        rel_none = (anded == '0);
        rel_all  = (anded == cmp_b_i);
    end

    // Bit-test positions: from the operand or from the instruction fields
    always_comb begin
        pos_reg     = cmp_b_i[BIT_W-1:0];
        pos_imm     = {cond_i[0], bidx_i};
        bit_clr_reg = ~opa_i[pos_reg];
        bit_clr_imm = ~opa_i[pos_imm];
    end

    // Select the relation for the test code and flag codes a class lacks
    always_comb begin
        base  = 1'b0;
        legal = 1'b1;
        unique case (cond_i[2:0])
            TST_MNONE: base = rel_none;
            TST_EQ:    base = rel_eq;
            TST_LT:    base = rel_lt;
            TST_LTU:   base = rel_ltu;
            TST_MALL:  base = rel_all;
            TST_BREG:  base = bit_clr_reg;
            default:   base = bit_clr_imm;
        endcase
        unique case (brc_cls_e'(class_i))
            CLS_REG:   legal = 1'b1;
            CLS_SHORT: begin
                base  = rel_eq;
                legal = 1'b1;
            end
            default:   legal = (cond_i[2:0] == TST_EQ) || (cond_i[2:0] == TST_LT)
                               || (cond_i[2:0] == TST_LTU);
        endcase
    end

    // Apply the sense bit only to legal tests
    always_comb taken_o = legal & (base ^ cond_i[3]);

endmodule

// File: rtl/brc_target_gen.sv
// Forms the next address: branch address plus four plus the offset, with
// the offset width and signedness picked by class; fall-through otherwise.
module brc_target_gen
    import brc_pkg::*;
#(
    parameter int XLEN    = BRC_XLEN,
    parameter int OFF_W   = 12,
    parameter int NARROW_W = 8,
    parameter int SHORT_W = 6,
    parameter int STEP    = 4
) (
    input  logic [1:0]       class_i,
    input  logic             taken_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  fall_pc_i,
    input  logic [OFF_W-1:0] offset_i,
    output logic [XLEN-1:0]  target_o
);

    logic [XLEN-1:0] off_narrow, off_wide, off_short, off_sel, branch_pc;

    // Extend the three offset forms to the datapath width
    always_comb begin
        off_narrow = {{(XLEN-NARROW_W){offset_i[NARROW_W-1]}}, offset_i[NARROW_W-1:0]};
        off_wide   = {{(XLEN-OFF_W){offset_i[OFF_W-1]}}, offset_i};
        off_short  = {{(XLEN-SHORT_W){1'b0}}, offset_i[SHORT_W-1:0]};
    end

    // Pick the offset form by class
    always_comb begin
        unique case (brc_cls_e'(class_i))
            CLS_ZERO:  off_sel = off_wide;
            CLS_SHORT: off_sel = off_short;
            default:   off_sel = off_narrow;
        endcase
    end

    // Sum the target and choose between it and the fall-through address
    always_comb begin
        branch_pc = pc_i + XLEN'(STEP) + off_sel;
        target_o  = taken_i ? branch_pc : fall_pc_i;
    end

endmodule

// File: rtl/brc_unit.sv
// Branch condition evaluator top: comparand select, condition test and
// target adder, with one register stage on the result. Assumes the issuing
// stage holds the inputs stable around the sampling edge.
module brc_unit
    import brc_pkg::*;
#(
    parameter int XLEN  = BRC_XLEN,
    parameter int OFF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [1:0]       class_i,
    input  logic [3:0]       cond_i,
    input  logic [3:0]       cidx_i,
    input  logic [3:0]       bidx_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  fall_pc_i,
    input  logic [XLEN-1:0]  opa_i,
    input  logic [XLEN-1:0]  opb_i,
    input  logic [OFF_W-1:0] offset_i,
    output logic             res_valid_o,
    output logic             taken_o,
    output logic [XLEN-1:0]  target_o
);

    logic [XLEN-1:0] cmp_b;
    logic            taken_c;
    logic [XLEN-1:0] target_c;

    brc_operand_sel #(.XLEN(XLEN), .TBL_N(16)) u_sel (
        .class_i (class_i),
        .test_i  (cond_i[2:0]),
        .cidx_i  (cidx_i),
        .opb_i   (opb_i),
        .cmp_b_o (cmp_b)
    );

    brc_cond_eval #(.XLEN(XLEN)) u_eval (
        .class_i (class_i),
        .cond_i  (cond_i),
        .bidx_i  (bidx_i),
        .opa_i   (opa_i),
        .cmp_b_i (cmp_b),
        .taken_o (taken_c)
    );

    brc_target_gen #(.XLEN(XLEN), .OFF_W(OFF_W)) u_tgt (
        .class_i   (class_i),
        .taken_i   (taken_c),
        .pc_i      (pc_i),
        .fall_pc_i (fall_pc_i),
        .offset_i  (offset_i),
        .target_o  (target_c)
    );

    // Result register: capture on a request, drop the decision when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
            taken_o     <= 1'b0;
            target_o    <= '0;
        end else begin
            res_valid_o <= valid_i;
            taken_o     <= valid_i & taken_c;
            if (valid_i) begin
                target_o <= target_c;
            end
        end
    end

endmodule

// File: rtl/brc_unit_chk.sv
// Port-level properties of the branch evaluator, bound to every instance.
module brc_unit_chk #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic [1:0]       class_i,
    input logic [3:0]       cond_i,
    input logic [3:0]       cidx_i,
    input logic [3:0]       bidx_i,
    input logic [XLEN-1:0]  pc_i,
    input logic [XLEN-1:0]  fall_pc_i,
    input logic [XLEN-1:0]  opa_i,
    input logic [XLEN-1:0]  opb_i,
    input logic [OFF_W-1:0] offset_i,
    input logic             res_valid_o,
    input logic             taken_o,
    input logic [XLEN-1:0]  target_o
);

    p_req_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> res_valid_o);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!res_valid_o && !taken_o && $stable(target_o)));

    p_fallthrough_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && rst_n) |=> (taken_o || target_o == $past(fall_pc_i)));

    p_reg_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && class_i == 2'd0 && cond_i == 4'd1)
        |=> (taken_o == ($past(opa_i) == $past(opb_i))));

    p_short_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && class_i == 2'd3 && opa_i == '0 && !cond_i[3])
        |=> (taken_o && target_o == $past(pc_i) + 32'd4 + {26'd0, $past(offset_i[5:0])}));

    p_unused_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (class_i == 2'd1 || class_i == 2'd2)
         && !(cond_i[2:0] inside {3'd1, 3'd2, 3'd3}))
        |=> !taken_o);

    // Unused inputs here on purpose are only observed through the design
    logic unused_ok;
    assign unused_ok = ^{cidx_i, bidx_i};

endmodule

bind brc_unit brc_unit_chk #(.XLEN(XLEN), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/brc_unit_tb.sv
module brc_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [1:0]  class_i = '0;
    logic [3:0]  cond_i = '0, cidx_i = '0, bidx_i = '0;
    logic [31:0] pc_i = '0, fall_pc_i = '0, opa_i = '0, opb_i = '0;
    logic [11:0] offset_i = '0;
    logic        res_valid_o, taken_o;
    logic [31:0] target_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    brc_unit u_dut (.*);

    function automatic logic [31:0] stab(input logic [3:0] i);
        case (i)
            0: return 32'hFFFF_FFFF;  9: return 10; 10: return 12; 11: return 16;
            12: return 32; 13: return 64; 14: return 128; 15: return 256;
            default: return {28'd0, i};
        endcase
    endfunction

    function automatic logic [31:0] utab(input logic [3:0] i);
        if (i == 0) return 32768;
        if (i == 1) return 65536;
        return stab(i);
    endfunction

    function automatic logic rel(input logic [2:0] t, input logic [31:0] a, input logic [31:0] b);
        case (t)
            1: return a == b;
            2: return $signed(a) < $signed(b);
            default: return a < b;
        endcase
    endfunction

    function automatic logic m_taken(input logic [1:0] cl, input logic [3:0] c,
                                     input logic [3:0] bi, input logic [31:0] a,
                                     input logic [31:0] b, input logic [3:0] ci);
        logic base;
        logic [31:0] k;
        case (cl)
            0: case (c[2:0])
                   0: base = (a & b) == 0;
                   4: base = (a & b) == b;
                   5: base = !a[b[4:0]];
                   6, 7: base = !a[{c[0], bi}];
                   default: base = rel(c[2:0], a, b);
               endcase
            1, 2: begin
                if (!(c[2:0] inside {3'd1, 3'd2, 3'd3})) return 1'b0;
                k = (cl == 2) ? 32'd0 : (c[2:0] == 3) ? utab(ci) : stab(ci);
                base = rel(c[2:0], a, k);
            end
            default: base = (a == 0);
        endcase
        return base ^ c[3];
    endfunction

    function automatic string req_of(input logic [1:0] cl, input logic [3:0] c);
        if (cl == 1) return "R7";
        if (cl == 2) return "R8";
        if (cl == 3) return "R9";
        case (c[2:0])
            0, 4: return "R4";
            5: return "R5";
            6, 7: return "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Drive one request at a falling edge, sample after the next rising edge
    task automatic run(input logic [1:0] cl, input logic [3:0] c, input logic [3:0] ci,
                       input logic [3:0] bi, input logic [31:0] a, input logic [31:0] b,
                       input logic [11:0] off, input string rq);
        logic t;
        logic [31:0] tg;
        class_i = cl; cond_i = c; cidx_i = ci; bidx_i = bi;
        opa_i = a; opb_i = b; offset_i = off;
        pc_i = $urandom; fall_pc_i = $urandom; valid_i = 1'b1;
        t = m_taken(cl, c, bi, a, b, ci);
        if (!t) tg = fall_pc_i;
        else if (cl == 2) tg = pc_i + 4 + {{20{off[11]}}, off};
        else if (cl == 3) tg = pc_i + 4 + {26'd0, off[5:0]};
        else tg = pc_i + 4 + {{24{off[7]}}, off[7:0]};
        @(negedge clk);
        check("R2", {31'd0, res_valid_o}, 32'd1);
        check(rq, {31'd0, taken_o}, {31'd0, t});
        check(t ? rq : "R11", target_o, tg);
    endtask

    initial begin
        #(5ns * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        logic [31:0] hold;
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        check("R1", {30'd0, res_valid_o, taken_o}, 32'd0);
        check("R1", target_o, 32'd0);
        rst_n = 1'b1;

        // R7: every table entry hits equality, and each entry orders correctly
        for (int i = 0; i < 16; i++) begin
            run(2'd1, 4'd1, 4'(i), 4'd0, stab(4'(i)), 32'd0, 12'h010, "R7");
            run(2'd1, 4'd3, 4'(i), 4'd0, utab(4'(i)) - 1, 32'd0, 12'h0F0, "R7");
            run(2'd1, 4'd11, 4'(i), 4'd0, utab(4'(i)), 32'd0, 12'h004, "R7");
        end
        run(2'd1, 4'd2, 4'd0, 4'd0, 32'h8000_0000, 32'd0, 12'h022, "R7");
        // R3: signed versus unsigned boundary
        run(2'd0, 4'd2, 4'd0, 4'd0, 32'h8000_0000, 32'd1, 12'h080, "R3");
        run(2'd0, 4'd3, 4'd0, 4'd0, 32'h8000_0000, 32'd1, 12'h080, "R3");
        run(2'd0, 4'd9, 4'd0, 4'd0, 32'd7, 32'd7, 12'h0, "R3");
        // R4: mask tests
        run(2'd0, 4'd0, 4'd0, 4'd0, 32'hF0F0_0000, 32'h0F0F_FFFF, 12'h1, "R4");
        run(2'd0, 4'd4, 4'd0, 4'd0, 32'hFFFF_0000, 32'h0001_0000, 12'h2, "R4");
        run(2'd0, 4'd12, 4'd0, 4'd0, 32'hFFFF_0000, 32'h0000_8000, 12'h3, "R4");
        // R5, R6: bit 31 via register and via immediate
        run(2'd0, 4'd13, 4'd0, 4'd0, 32'h8000_0000, 32'hFFFF_FFFF, 12'h7F, "R5");
        run(2'd0, 4'd15, 4'd0, 4'd15, 32'h8000_0000, 32'd0, 12'h7F, "R6");
        run(2'd0, 4'd6, 4'd0, 4'd15, 32'h8000_0000, 32'd0, 12'h7F, "R6");
        // R8: wide negative offset; R9: largest short offset
        run(2'd2, 4'd2, 4'd0, 4'd0, 32'hFFFF_FFFF, 32'd0, 12'h800, "R8");
        run(2'd3, 4'd0, 4'd0, 4'd0, 32'd0, 32'd5, 12'hFFF, "R9");
        run(2'd3, 4'd8, 4'd0, 4'd0, 32'd9, 32'd5, 12'hFFF, "R9");
        // R10: unused codes never taken
        run(2'd1, 4'd8, 4'd0, 4'd0, 32'd0, 32'd0, 12'h5, "R10");
        run(2'd2, 4'd12, 4'd0, 4'd0, 32'd0, 32'd0, 12'h5, "R10");

        // R2: idle cycle drops the decision and keeps the target
        hold = target_o;
        valid_i = 1'b0;
        opa_i = 32'd0;
        @(negedge clk);
        check("R2", {30'd0, res_valid_o, taken_o}, 32'd0);
        check("R2", target_o, hold);

        for (int n = 0; n < 3000; n++) begin
            logic [1:0] cl;
            logic [3:0] c;
            logic [31:0] a, b;
            cl = 2'($urandom);
            c = 4'($urandom);
            a = $urandom;
            b = $urandom;
            case ($urandom % 4)
                0: b = a;
                1: a = 32'(signed'(8'($urandom)));
                2: a = 0;
                default: ;
            endcase
            if (cl == 1 && ($urandom % 2)) a = (c[2:0] == 3) ? utab(4'(n)) : stab(4'(n));
            run(cl, c, 4'(n), 4'($urandom), a, b, 12'($urandom),
                (cl == 1 || cl == 2) && !(c[2:0] inside {3'd1, 3'd2, 3'd3})
                    ? "R10" : req_of(cl, c));
        end
        valid_i = 1'b0;
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule